// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the sync and framing signals for one display output. It counts pixels across a line and lines down a frame, and derives horizontal sync, vertical sync, data enable, a field flag and a start-of-frame pulse from a set of geometry inputs.

The line length is the horizontal active-end value. The frame height is the first field's active-end line for progressive rasters. For two-field interlaced rasters it is the second field's active-end line. In interlaced mode the second field's vertical sync starts and stops part-way along a line, at the hsync start plus a programmable offset. A run bit starts the counters and a field-mode bit selects interlaced operation. The geometry is copied into working registers only while the run bit is low.

Top module: `rtg_top`

## Requirements
- R1: While running, the horizontal count steps once per clock from 0 to `h_total`−1 and then wraps, so a frame lasts `h_total` × (vertical total) clocks.
- R2: `de_o` is high exactly when the horizontal count lies in [`h_act_beg`, `h_total`) and the line lies in field 0's window [`f0_act_beg`, `f0_act_end`). In interlaced mode it is also high when the line lies in field 1's window [`f1_act_beg`, `f1_act_end`). It is low on every other line.
- R3: Horizontal sync is active for the counts in [`hs_beg`, `hs_end`) on every line.
- R4: The polarity inputs `hs_pol` and `vs_pol` set each sync's active level: 0 means active-high and 1 means active-low. While stopped, both syncs sit at their inactive level, and `de_o`, `field_o` and `sof_o` are 0.
- R5: In progressive mode the vertical total is `f0_act_end`. Vertical sync is active from position (line `f0_vs_beg`, count `hs_beg`) up to, but not including, position (line `f0_vs_end`, count `hs_beg`).
- R6: In interlaced mode (`ilace_en`=1) the vertical total is `f1_act_end`. A second vertical sync window is added. It runs from (line `f1_vs_beg`, count `hs_beg`+`vs_hoff`) up to (line `f1_vs_end`, same count).
- R7: In interlaced mode `field_o` is 1 on lines from `f0_act_end` to the end of the frame and 0 before them. In progressive mode it is always 0.
- R8: `sof_o` is a one-clock pulse for position (line 0, count 0). It first appears on the second clock edge that samples `run_en` high.
- R9: A synchronous active-high `rst` clears the counters and the working geometry, and drives every output to 0.
- R10: The geometry inputs and `ilace_en` are copied into the working registers only on clock edges where `run_en` is low. Changes made while running have no effect until the block is stopped and started again.
- R11: Every output is registered and reflects the counter position of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run bit: high runs the counters, low stops them and opens the geometry copy |
| ilace_en | input | 1 | Field-mode bit: 1 selects a two-field interlaced raster |
| h_total | input | H_W | Line length, equal to the horizontal active end |
| h_act_beg | input | H_W | First active pixel count |
| hs_beg | input | H_W | Horizontal sync start count |
| hs_end | input | H_W | Horizontal sync stop count (exclusive) |
| hs_pol | input | 1 | Horizontal sync polarity, 1 means active-low |
| vs_pol | input | 1 | Vertical sync polarity, 1 means active-low |
| vs_hoff | input | H_W | Offset from `hs_beg` to field 1's vertical sync edges |
| f0_act_beg | input | V_W | Field 0 first active line |
| f0_act_end | input | V_W | Field 0 active end; also the field-change line and the progressive total |
| f1_act_beg | input | V_W | Field 1 first active line |
| f1_act_end | input | V_W | Field 1 active end; also the interlaced total |
| f0_vs_beg | input | V_W | Field 0 vertical sync start line |
| f0_vs_end | input | V_W | Field 0 vertical sync stop line |
| f1_vs_beg | input | V_W | Field 1 vertical sync start line |
| f1_vs_end | input | V_W | Field 1 vertical sync stop line |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable (active video) |
| field_o | output | 1 | Field flag |
| sof_o | output | 1 | Start-of-frame pulse |

## Verification
The hardest case to reach is field 1's vertical sync, whose edges fall in the middle of a line. It occurs only after the counters have passed the whole of field 0. The stimulus uses small rasters whose numbers keep the offsets easy to check: a 24-clock line, an offset of 12, and a 22-line frame. Each run lasts several whole frames. The bench measures the clock distance from each start-of-frame pulse to both vertical sync edges, and counts the data-enable and field clocks in each frame. A further run changes every geometry input while the block is running and confirms that the frame length only changes after a stop and restart.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned H_W = 12;
  localparam int unsigned V_W = 11;

  typedef struct packed {
    logic           ilace;
    logic [H_W-1:0] htot;
    logic [H_W-1:0] hab;
    logic [H_W-1:0] hsb;
    logic [H_W-1:0] hse;
    logic           hpol;
    logic           vpol;
    logic [H_W-1:0] f1_vs_hpos;
    logic [V_W-1:0] f0_ab;
    logic [V_W-1:0] f0_ae;
    logic [V_W-1:0] f1_ab;
    logic [V_W-1:0] f1_ae;
    logic [V_W-1:0] f0_vb;
    logic [V_W-1:0] f0_ve;
    logic [V_W-1:0] f1_vb;
    logic [V_W-1:0] f1_ve;
  } geom_t;

  function automatic logic pos_in_win(
    input logic [V_W-1:0] line, input logic [H_W-1:0] col,
    input logic [V_W-1:0] lb,   input logic [V_W-1:0] le,
    input logic [H_W-1:0] cpt);
    logic past_start, before_stop;
    past_start  = (line > lb) || ((line == lb) && (col >= cpt));
    before_stop = (line < le) || ((line == le) && (col < cpt));
    return past_start && before_stop;
  endfunction
endpackage

// File: rtl/rtg_geom_shadow.sv
module rtg_geom_shadow
  import rtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run_en,
  input  geom_t geom_in,
  output geom_t geom_q
);
  always_ff @(posedge clk) begin
    if (rst) geom_q <= '0;
    else if (!run_en) geom_q <= geom_in;
  end

  // R10: working copy frozen while running
  p_geom_hold_r10: assert property (@(posedge clk) disable iff (rst)
    run_en |=> $stable(geom_q));
endmodule

// File: rtl/rtg_raster_cnt.sv
module rtg_raster_cnt #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [HW-1:0] htot,
  input  logic [VW-1:0] vtot,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          run_q
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic h_last, v_last;
  assign h_last = (hcnt == htot - H_ONE);
  assign v_last = (vcnt == vtot - V_ONE);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      hcnt  <= '0;
      vcnt  <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (h_last) begin
          hcnt <= '0;
          vcnt <= v_last ? '0 : vcnt + V_ONE;
        end else begin
          hcnt <= hcnt + H_ONE;
        end
      end
    end
  end

  // R1: horizontal count stays inside the line
  p_h_range_r1: assert property (@(posedge clk) disable iff (rst)
    (run_q && htot != '0) |-> (hcnt < htot));
  // R5: line count stays inside the frame
  p_v_range_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && vtot != '0) |-> (vcnt < vtot));
  // R1: end of frame returns to the origin
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (run_q && run_en && h_last && v_last) |=> (hcnt == '0 && vcnt == '0));
endmodule

// File: rtl/rtg_sync_out.sv
module rtg_sync_out
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           run_q,
  input  geom_t          g,
  input  logic [H_W-1:0] hcnt,
  input  logic [V_W-1:0] vcnt,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           field_o,
  output logic           sof_o
);
  logic h_act, v_act0, v_act1, hs_act, vs_act0, vs_act1, vs_act, fld;

  assign h_act   = (hcnt >= g.hab) && (hcnt < g.htot);
  assign v_act0  = (vcnt >= g.f0_ab) && (vcnt < g.f0_ae);
  assign v_act1  = g.ilace && (vcnt >= g.f1_ab) && (vcnt < g.f1_ae);
  assign hs_act  = (hcnt >= g.hsb) && (hcnt < g.hse);
  assign vs_act0 = pos_in_win(vcnt, hcnt, g.f0_vb, g.f0_ve, g.hsb);
  assign vs_act1 = g.ilace && pos_in_win(vcnt, hcnt, g.f1_vb, g.f1_ve, g.f1_vs_hpos);
  assign vs_act  = vs_act0 || vs_act1;
  assign fld     = g.ilace && (vcnt >= g.f0_ae);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      field_o <= 1'b0;
      sof_o   <= 1'b0;
    end else if (!run_q) begin
      hsync_o <= g.hpol;
      vsync_o <= g.vpol;
      de_o    <= 1'b0;
      field_o <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      hsync_o <= hs_act ^ g.hpol;
      vsync_o <= vs_act ^ g.vpol;
      de_o    <= h_act && (v_act0 || v_act1);
      field_o <= fld;
      sof_o   <= (hcnt == '0) && (vcnt == '0);
    end
  end

  // R4: idle outputs while stopped
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (!de_o && !sof_o && !field_o));
  // R8: start-of-frame lasts one clock
  p_sof_single_r8: assert property (@(posedge clk) disable iff (rst)
    (sof_o && g.htot > 12'd1) |=> !sof_o);
  // R7: no field flag in progressive mode
  p_field_prog_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !g.ilace) |=> !field_o);
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic           ilace_en,
  input  logic [H_W-1:0] h_total,
  input  logic [H_W-1:0] h_act_beg,
  input  logic [H_W-1:0] hs_beg,
  input  logic [H_W-1:0] hs_end,
  input  logic           hs_pol,
  input  logic           vs_pol,
  input  logic [H_W-1:0] vs_hoff,
  input  logic [V_W-1:0] f0_act_beg,
  input  logic [V_W-1:0] f0_act_end,
  input  logic [V_W-1:0] f1_act_beg,
  input  logic [V_W-1:0] f1_act_end,
  input  logic [V_W-1:0] f0_vs_beg,
  input  logic [V_W-1:0] f0_vs_end,
  input  logic [V_W-1:0] f1_vs_beg,
  input  logic [V_W-1:0] f1_vs_end,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           field_o,
  output logic           sof_o
);
  geom_t geom_in, geom_q;
  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt, vtot;
  logic run_q;

  always_comb begin
    geom_in.ilace      = ilace_en;
    geom_in.htot       = h_total;
    geom_in.hab        = h_act_beg;
    geom_in.hsb        = hs_beg;
    geom_in.hse        = hs_end;
    geom_in.hpol       = hs_pol;
    geom_in.vpol       = vs_pol;
    geom_in.f1_vs_hpos = hs_beg + vs_hoff;
    geom_in.f0_ab      = f0_act_beg;
    geom_in.f0_ae      = f0_act_end;
    geom_in.f1_ab      = f1_act_beg;
    geom_in.f1_ae      = f1_act_end;
    geom_in.f0_vb      = f0_vs_beg;
    geom_in.f0_ve      = f0_vs_end;
    geom_in.f1_vb      = f1_vs_beg;
    geom_in.f1_ve      = f1_vs_end;
  end

  assign vtot = geom_q.ilace ? geom_q.f1_ae : geom_q.f0_ae;

  rtg_geom_shadow u_shadow (
    .clk(clk), .rst(rst), .run_en(run_en), .geom_in(geom_in), .geom_q(geom_q)
  );

  rtg_raster_cnt #(.HW(H_W), .VW(V_W)) u_cnt (
    .clk(clk), .rst(rst), .run_en(run_en), .htot(geom_q.htot), .vtot(vtot),
    .hcnt(hcnt), .vcnt(vcnt), .run_q(run_q)
  );

  rtg_sync_out u_out (
    .clk(clk), .rst(rst), .run_q(run_q), .g(geom_q), .hcnt(hcnt), .vcnt(vcnt),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o),
    .sof_o(sof_o)
  );
endmodule

// File: tb/test_rtg_top.sv
module test_rtg_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0, ilace_en = 1'b0, hs_pol = 1'b0, vs_pol = 1'b0;
  logic [11:0] h_total = '0, h_act_beg = '0, hs_beg = '0, hs_end = '0, vs_hoff = '0;
  logic [10:0] f0_act_beg = '0, f0_act_end = '0, f1_act_beg = '0, f1_act_end = '0;
  logic [10:0] f0_vs_beg = '0, f0_vs_end = '0, f1_vs_beg = '0, f1_vs_end = '0;
  logic hsync_o, vsync_o, de_o, field_o, sof_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtg_top i_rtg_top (.*);

  // behavioural reference model state
  int m_h = 0, m_v = 0;
  bit m_run = 0;
  int c_il = 0, c_ht = 0, c_ha = 0, c_hb = 0, c_he = 0, c_hp = 0, c_vp = 0, c_pt = 0;
  int c_a0 = 0, c_e0 = 0, c_a1 = 0, c_e1 = 0, c_s0 = 0, c_t0 = 0, c_s1 = 0, c_t1 = 0;
  bit e_hs = 0, e_vs = 0, e_de = 0, e_fd = 0, e_sf = 0;

  function automatic bit later_eq(int v, int h, int lv, int lh);
    return (v > lv) || (v == lv && h >= lh);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {e_hs, e_vs, e_de, e_fd, e_sf} = '0;
      m_h = 0; m_v = 0; m_run = 0;
      {c_il, c_ht, c_ha, c_hb, c_he, c_hp, c_vp, c_pt} = '0;
      {c_a0, c_e0, c_a1, c_e1, c_s0, c_t0, c_s1, c_t1} = '0;
    end else begin
      int vt;
      bit vsa;
      vt = (c_il != 0) ? c_e1 : c_e0;
      if (!m_run) begin
        e_hs = c_hp[0]; e_vs = c_vp[0]; e_de = 0; e_fd = 0; e_sf = 0;
      end else begin
        vsa = later_eq(m_v, m_h, c_s0, c_hb) && !later_eq(m_v, m_h, c_t0, c_hb);
        if (c_il != 0)
          vsa = vsa || (later_eq(m_v, m_h, c_s1, c_pt) && !later_eq(m_v, m_h, c_t1, c_pt));
        e_hs = ((m_h >= c_hb && m_h < c_he) ? 1'b1 : 1'b0) ^ c_hp[0];
        e_vs = vsa ^ c_vp[0];
        e_de = (m_h >= c_ha && m_h < c_ht) &&
               ((m_v >= c_a0 && m_v < c_e0) || (c_il != 0 && m_v >= c_a1 && m_v < c_e1));
        e_fd = (c_il != 0) && (m_v >= c_e0);
        e_sf = (m_h == 0 && m_v == 0);
      end
      if (!run_en) begin
        m_h = 0; m_v = 0; m_run = 0;
        c_il = ilace_en; c_ht = h_total; c_ha = h_act_beg; c_hb = hs_beg; c_he = hs_end;
        c_hp = hs_pol; c_vp = vs_pol; c_pt = (hs_beg + vs_hoff) % 4096;
        c_a0 = f0_act_beg; c_e0 = f0_act_end; c_a1 = f1_act_beg; c_e1 = f1_act_end;
        c_s0 = f0_vs_beg; c_t0 = f0_vs_end; c_s1 = f1_vs_beg; c_t1 = f1_vs_end;
      end else begin
        if (m_run) begin
          if (m_h == c_ht - 1) begin
            m_h = 0;
            m_v = (m_v == vt - 1) ? 0 : m_v + 1;
          end else m_h = m_h + 1;
        end
        m_run = 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the model (R11 latency included)
  always @(negedge clk) if (!done) begin
    chk("R3", "hsync_o", hsync_o, e_hs);
    chk("R5", "vsync_o", vsync_o, e_vs);
    chk("R2", "de_o", de_o, e_de);
    chk("R7", "field_o", field_o, e_fd);
    chk("R8", "sof_o", sof_o, e_sf);
  end

  int f_len, f_de, f_fd, f_r0, f_r1;

  task automatic grab_frame(bit vpol);
    bit pv, av;
    int n;
    do @(negedge clk); while (!sof_o);
    n = 0; f_de = 0; f_fd = 0; f_r0 = -1; f_r1 = -1;
    pv = vsync_o ^ vpol;
    forever begin
      @(negedge clk);
      n++;
      if (sof_o) break;
      if (de_o) f_de++;
      if (field_o) f_fd++;
      av = vsync_o ^ vpol;
      if (av && !pv) begin
        if (f_r0 < 0) f_r0 = n; else if (f_r1 < 0) f_r1 = n;
      end
      pv = av;
    end
    f_len = n;
  endtask

  task automatic set_prog();
    ilace_en = 0; h_total = 20; h_act_beg = 6; hs_beg = 2; hs_end = 5;
    hs_pol = 0; vs_pol = 0; vs_hoff = 0;
    f0_act_beg = 3; f0_act_end = 12; f1_act_beg = 0; f1_act_end = 0;
    f0_vs_beg = 1; f0_vs_end = 2; f1_vs_beg = 0; f1_vs_end = 0;
  endtask

  task automatic set_ilace();
    ilace_en = 1; h_total = 24; h_act_beg = 6; hs_beg = 2; hs_end = 5;
    hs_pol = 1; vs_pol = 1; vs_hoff = 12;
    f0_act_beg = 3; f0_act_end = 10; f1_act_beg = 14; f1_act_end = 22;
    f0_vs_beg = 1; f0_vs_end = 2; f1_vs_beg = 11; f1_vs_end = 12;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "hsync in reset", hsync_o, 0);
    chk("R9", "vsync in reset", vsync_o, 0);
    chk("R9", "de/sof in reset", de_o | sof_o | field_o, 0);
    rst = 0;

    // progressive raster
    set_prog();
    repeat (3) @(negedge clk);
    run_en = 1;
    @(negedge clk); chk("R8", "no sof one edge after start", sof_o, 0);
    @(negedge clk); chk("R8", "sof two edges after start", sof_o, 1);
    grab_frame(0);
    chk("R1", "progressive frame length", f_len, 240);
    chk("R2", "progressive de clocks", f_de, 126);
    chk("R5", "vsync start offset", f_r0, 22);
    chk("R5", "single vsync per frame", f_r1, -1);
    chk("R7", "field clocks progressive", f_fd, 0);

    // R10: change geometry while running
    set_ilace();
    grab_frame(0);
    chk("R10", "frame length after live change", f_len, 240);
    chk("R10", "de clocks after live change", f_de, 126);

    // R4: stopped outputs at inactive level (active-low now)
    run_en = 0;
    repeat (3) @(negedge clk);
    chk("R4", "hsync idle active-low", hsync_o, 1);
    chk("R4", "vsync idle active-low", vsync_o, 1);
    chk("R4", "de idle", de_o, 0);

    // interlaced raster
    run_en = 1;
    grab_frame(1);
    grab_frame(1);
    chk("R6", "interlaced frame length", f_len, 528);
    chk("R2", "interlaced de clocks", f_de, 270);
    chk("R6", "field 0 vsync offset", f_r0, 26);
    chk("R6", "field 1 vsync offset", f_r1, 278);
    chk("R7", "field clocks interlaced", f_fd, 288);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule